// File: doc/BRIEF.md
# Triggered Target Data FIFO Pair

This block sits between a bus-target protocol engine and a software register interface and holds the message bytes in both directions. The outbound (to-bus) queue is loaded one byte per write by software and drained by the bus engine with a pop strobe. Each loaded byte carries a ninth bit that marks the last byte of a message. The inbound (from-bus) queue is filled by the bus engine with a push strobe. Software drains it either one byte or one byte pair per read access.

A control word carries several fields. Two write-only flush commands each empty one queue. Two 2-bit threshold codes set the levels that drive the outbound and inbound trigger outputs. These codes can be rewritten only by a write that also sets an unlock bit. The read view of the control word reports both fill counts, the outbound-full flag and the inbound-empty flag.

Misuse is absorbed rather than acted on. A push into a full queue and a pop from a queue holding too little data are both ignored. Each such event raises a sticky error flag.

Top module: `tgt_fifo_pair`

## Requirements
- R1: After reset both queues are empty and the control read word is 32'h8000_00B0: outbound code 3 in bits 5:4, inbound code 2 in bits 7:6, inbound-empty bit 31 set. `rx_rdata` and `err_flags` are 0, `tx_trig` is 1 and `rx_trig` is 0.
- R2: Bits 7:4 of the control word (outbound code in 5:4, inbound code in 7:6) take the written value only when the same write has bit 3 set. Any other write leaves them unchanged.
- R3: The bus side receives outbound bytes in load order. `bus_tx_data` and `bus_tx_last` show the oldest entry before and during the pop cycle, `bus_tx_last` repeats bit 8 of the software write that loaded it, and `bus_tx_avail` is 1 exactly when the outbound queue is not empty.
- R4: A byte read (`rx_rd` with `rx_rd_half`=0) on a non-empty inbound queue removes the oldest byte. From the next cycle, `rx_rdata` holds that byte in bits 7:0 and zero in bits 15:8.
- R5: A pair read (`rx_rd` with `rx_rd_half`=1) with at least two bytes stored removes two bytes. From the next cycle, `rx_rdata` holds the older byte in bits 7:0 and the next byte in bits 15:8. With fewer than two bytes stored, the read removes nothing and `rx_rdata` keeps its value.
- R6: The control read word holds the outbound count in bits 20:16 and the inbound count in bits 28:24. Bit 30 is set when the outbound count equals the depth (16), bit 31 is set when the inbound count is zero, and all other bits outside 7:4 read as zero.
- R7: A push into a full queue is ignored. It sets the sticky overflow flag of that queue: `err_flags[0]` for outbound, `err_flags[2]` for inbound.
- R8: A pop that the queue cannot satisfy is ignored. This covers an outbound pop when empty, an inbound byte read when empty and an inbound pair read with fewer than two bytes. It sets the sticky underflow flag: `err_flags[1]` for outbound, `err_flags[3]` for inbound.
- R9: A control write with bit 0 set empties the outbound queue, and bit 1 empties the inbound queue. Each flush also clears that queue's two error flags and takes priority over a push or pop in the same cycle.
- R10: Threshold code c selects level 1, 4, 8 or 15 for c = 0, 1, 2, 3. `tx_trig` is 1 while the outbound count is at most its level. `rx_trig` is 1 while the inbound count is at least its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control write data: flushes (bits 1:0), unlock (bit 3), codes (bits 7:4) |
| ctl_rdata | output | 32 | Control word read view |
| tx_wr | input | 1 | Software byte load strobe for the outbound queue |
| tx_wdata | input | 9 | Byte in bits 7:0, end-of-message mark in bit 8 |
| rx_rd | input | 1 | Software read strobe for the inbound queue |
| rx_rd_half | input | 1 | 1 selects a byte-pair read, 0 a single byte |
| rx_rdata | output | 16 | Registered result of the last accepted inbound read |
| bus_tx_pop | input | 1 | Bus engine takes the oldest outbound byte |
| bus_tx_data | output | 8 | Oldest outbound byte |
| bus_tx_last | output | 1 | End-of-message mark of the oldest outbound byte |
| bus_tx_avail | output | 1 | Outbound queue holds at least one byte |
| bus_rx_push | input | 1 | Bus engine stores a received byte |
| bus_rx_data | input | 8 | Received byte |
| tx_trig | output | 1 | Outbound count at or below its level |
| rx_trig | output | 1 | Inbound count at or above its level |
| err_flags | output | 4 | Sticky errors: 0 out-overflow, 1 out-underflow, 2 in-overflow, 3 in-underflow |

## Verification
The properties take the control read word as the only window on the fill counts. They rely on strobes changing only between clock edges, so a count seen at one edge is the count the pop or push acts on. The pair-read and overflow properties also assume that no flush of the same queue arrives in that cycle, and the pair-read property assumes no bus push arrives in the cycle of the read. The stimulus drives every strobe on the falling edge for one cycle. It never overlaps a software read with a bus push or a flush, so the expected queues in the scoreboard stay in step with the design.

// File: rtl/tfp_pkg.sv
`timescale 1ns/1ps
package tfp_pkg;
  // control word bit positions (software decodes these)
  localparam int CTL_FLUSH_TX  = 0;
  localparam int CTL_FLUSH_RX  = 1;
  localparam int CTL_UNLOCK    = 3;
  localparam int CTL_TXCODE_LO = 4;
  localparam int CTL_RXCODE_LO = 6;
  localparam int CTL_TXCNT_LO  = 16;
  localparam int CTL_RXCNT_LO  = 24;
  localparam int CTL_TXFULL    = 30;
  localparam int CTL_RXEMPTY   = 31;
  localparam int CNT_FIELD_W   = 5;

  typedef logic [1:0] trig_code_t;

  // threshold code to level in entries
  function automatic int unsigned trig_level(input trig_code_t code, input int unsigned depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 1;
    endcase
  endfunction
endpackage

// File: rtl/tfp_fifo.sv
`timescale 1ns/1ps
module tfp_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int NHEAD = 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        push,
  input  logic [DW-1:0]               push_data,
  input  logic                        pop,
  input  logic                        pop_two,
  output logic [NHEAD-1:0][DW-1:0]    heads,
  output logic [CW-1:0]               count,
  output logic                        pop_ack,
  output logic                        ovf_err,
  output logic                        unf_err
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok, want_two, is_full;
  logic [CW-1:0] pop_amt;
  logic [NHEAD-1:0][AW-1:0] rd_idx;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign want_two = pop_two && (NHEAD > 1);
  assign pop_amt  = want_two ? CW'(2) : CW'(1);
  assign is_full  = (count == CW'(DEPTH));
  assign push_ok  = push && !is_full && !flush;
  assign pop_ok   = pop && !flush && (count >= pop_amt);
  assign pop_ack  = pop_ok;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= want_two ? step(step(rd_ptr)) : step(rd_ptr);
      count <= count + CW'(push_ok) - (pop_ok ? pop_amt : CW'(0));
      if (push && is_full) ovf_err <= 1'b1;
      if (pop && !pop_ok)  unf_err <= 1'b1;
    end
  end

  // show-ahead view of the oldest NHEAD entries
  for (genvar i = 0; i < NHEAD; i++) begin : g_head
    if (i == 0) begin : g_first
      assign rd_idx[i] = rd_ptr;
    end else begin : g_next
      assign rd_idx[i] = step(rd_idx[i-1]);
    end
    assign heads[i] = mem[rd_idx[i]];
  end
endmodule

// File: rtl/tfp_ctl.sv
`timescale 1ns/1ps
module tfp_ctl
  import tfp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  output logic          flush_tx,
  output logic          flush_rx,
  output logic [31:0]   ctl_rdata,
  output logic          tx_trig,
  output logic          rx_trig
);
  trig_code_t    tx_code, rx_code;
  logic [CW-1:0] tx_lvl, rx_lvl;

  assign flush_tx = ctl_wr && ctl_wdata[CTL_FLUSH_TX];
  assign flush_rx = ctl_wr && ctl_wdata[CTL_FLUSH_RX];

  // codes only move when the same write carries the unlock bit
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_code <= 2'd3;
      rx_code <= 2'd2;
    end else if (ctl_wr && ctl_wdata[CTL_UNLOCK]) begin
      tx_code <= ctl_wdata[CTL_TXCODE_LO +: 2];
      rx_code <= ctl_wdata[CTL_RXCODE_LO +: 2];
    end
  end

  assign tx_lvl  = CW'(trig_level(tx_code, DEPTH));
  assign rx_lvl  = CW'(trig_level(rx_code, DEPTH));
  assign tx_trig = (tx_count <= tx_lvl);
  assign rx_trig = (rx_count >= rx_lvl);

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[CTL_TXCODE_LO +: 2]          = tx_code;
    ctl_rdata[CTL_RXCODE_LO +: 2]          = rx_code;
    ctl_rdata[CTL_TXCNT_LO +: CNT_FIELD_W] = CNT_FIELD_W'(tx_count);
    ctl_rdata[CTL_RXCNT_LO +: CNT_FIELD_W] = CNT_FIELD_W'(rx_count);
    ctl_rdata[CTL_TXFULL]                  = (tx_count == CW'(DEPTH));
    ctl_rdata[CTL_RXEMPTY]                 = (rx_count == '0);
  end
endmodule

// File: rtl/tgt_fifo_pair.sv
`timescale 1ns/1ps
module tgt_fifo_pair #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        tx_wr,
  input  logic [8:0]  tx_wdata,
  input  logic        rx_rd,
  input  logic        rx_rd_half,
  output logic [15:0] rx_rdata,
  input  logic        bus_tx_pop,
  output logic [7:0]  bus_tx_data,
  output logic        bus_tx_last,
  output logic        bus_tx_avail,
  input  logic        bus_rx_push,
  input  logic [7:0]  bus_rx_data,
  output logic        tx_trig,
  output logic        rx_trig,
  output logic [3:0]  err_flags
);
  logic                 flush_tx, flush_rx;
  logic [CW-1:0]        tx_count, rx_count;
  logic [0:0][8:0]      tx_heads;
  logic [1:0][7:0]      rx_heads;
  logic                 tx_ack, rx_ack;
  logic                 tx_ovf, tx_unf, rx_ovf, rx_unf;

  tfp_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .tx_count(tx_count), .rx_count(rx_count),
    .flush_tx(flush_tx), .flush_rx(flush_rx), .ctl_rdata(ctl_rdata),
    .tx_trig(tx_trig), .rx_trig(rx_trig)
  );

  // outbound: 9-bit entries, bit 8 = end-of-message
  tfp_fifo #(.DEPTH(DEPTH), .DW(9), .NHEAD(1)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx),
    .push(tx_wr), .push_data(tx_wdata),
    .pop(bus_tx_pop), .pop_two(1'b0),
    .heads(tx_heads), .count(tx_count), .pop_ack(tx_ack),
    .ovf_err(tx_ovf), .unf_err(tx_unf)
  );

  // inbound: two heads so a pair read completes in one access
  tfp_fifo #(.DEPTH(DEPTH), .DW(8), .NHEAD(2)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx),
    .push(bus_rx_push), .push_data(bus_rx_data),
    .pop(rx_rd), .pop_two(rx_rd_half),
    .heads(rx_heads), .count(rx_count), .pop_ack(rx_ack),
    .ovf_err(rx_ovf), .unf_err(rx_unf)
  );

  assign bus_tx_avail = (tx_count != '0);
  assign bus_tx_data  = tx_heads[0][7:0];
  assign bus_tx_last  = tx_heads[0][8] && bus_tx_avail && !tx_ack && 1'b1 || (tx_heads[0][8] && tx_ack);
  assign err_flags    = {rx_unf, rx_ovf, tx_unf, tx_ovf};

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_rdata <= '0;
    end else if (rx_ack) begin
      rx_rdata <= {rx_rd_half ? rx_heads[1] : 8'h00, rx_heads[0]};
    end
  end
endmodule

// File: rtl/tgt_fifo_pair_chk.sv
`timescale 1ns/1ps
module tgt_fifo_pair_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        ctl_wr,
  input logic [7:0]  ctl_wdata,
  input logic [31:0] ctl_rdata,
  input logic        tx_wr,
  input logic        rx_rd,
  input logic        rx_rd_half,
  input logic        bus_rx_push,
  input logic [15:0] rx_rdata,
  input logic [3:0]  err_flags
);
  logic [4:0] txc, rxc;
  assign txc = ctl_rdata[20:16];
  assign rxc = ctl_rdata[28:24];

  // R2: codes hold unless the write unlocks them
  p_locked_codes_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_wdata[3]) |=> $stable(ctl_rdata[7:4]));

  // R5: a satisfiable pair read removes exactly two bytes
  p_pair_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (rxc >= 5'd2 && rx_rd && rx_rd_half && !bus_rx_push && !(ctl_wr && ctl_wdata[1]))
    |=> (rxc == $past(rxc) - 5'd2));

  // R6: counts never exceed the depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (txc <= 5'(DEPTH)) && (rxc <= 5'(DEPTH)));

  // R7: push into a full outbound queue raises the overflow flag
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (txc == 5'(DEPTH) && tx_wr && !(ctl_wr && ctl_wdata[0])) |=> err_flags[0]);

  // R7: overflow flag stays until a flush of that queue
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_flags[0] && !(ctl_wr && ctl_wdata[0])) |=> err_flags[0]);

  // R8: inbound read on empty is ignored and flagged
  p_rx_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    (rxc == 5'd0 && rx_rd && !(ctl_wr && ctl_wdata[1])) |=> (err_flags[3] && $stable(rx_rdata)));

  // R9: flush empties the queue and clears its flags
  p_flush_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[1]) |=> (rxc == 5'd0 && err_flags[3:2] == 2'b00));

  p_flush_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[0]) |=> (txc == 5'd0 && err_flags[1:0] == 2'b00));
endmodule

bind tgt_fifo_pair tgt_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .tx_wr(tx_wr), .rx_rd(rx_rd), .rx_rd_half(rx_rd_half),
  .bus_rx_push(bus_rx_push), .rx_rdata(rx_rdata), .err_flags(err_flags)
);

// File: tb/tgt_fifo_pair_tb.sv
`timescale 1ns/1ps
module tgt_fifo_pair_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0;
  logic [7:0]  ctl_wdata = 0;
  logic [31:0] ctl_rdata;
  logic        tx_wr = 0;
  logic [8:0]  tx_wdata = 0;
  logic        rx_rd = 0, rx_rd_half = 0;
  logic [15:0] rx_rdata;
  logic        bus_tx_pop = 0;
  logic [7:0]  bus_tx_data;
  logic        bus_tx_last, bus_tx_avail;
  logic        bus_rx_push = 0;
  logic [7:0]  bus_rx_data = 0;
  logic        tx_trig, rx_trig;
  logic [3:0]  err_flags;

  always #2.5 clk = ~clk;

  tgt_fifo_pair #(.DEPTH(DEPTH)) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0]  tx_q[$];
  logic [7:0]  rx_q[$];
  logic [15:0] last_rd = 16'h0;
  logic [1:0]  txcode = 2'd3, rxcode = 2'd2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 15;
    endcase
  endfunction

  function automatic logic [31:0] exp_ctl();
    int t = tx_q.size();
    int r = rx_q.size();
    return {r == 0, t == DEPTH, 1'b0, 5'(r), 3'b0, 5'(t), 8'h00, rxcode, txcode, 4'h0};
  endfunction

  task automatic chk_status(input string tag);
    chk({tag, " ctl word"}, ctl_rdata, exp_ctl());
    chk("R10 tx_trig", {31'h0, tx_trig}, {31'h0, tx_q.size() <= lvl(txcode)});
    chk("R10 rx_trig", {31'h0, rx_trig}, {31'h0, rx_q.size() >= lvl(rxcode)});
  endtask

  task automatic ctl_write(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
    if (d[3]) begin txcode = d[5:4]; rxcode = d[7:6]; end
    if (d[0]) tx_q.delete();
    if (d[1]) rx_q.delete();
  endtask

  task automatic tx_push(input logic [7:0] d, input logic last);
    @(negedge clk); tx_wr = 1; tx_wdata = {last, d};
    if (tx_q.size() < DEPTH) tx_q.push_back({last, d});
    @(negedge clk); tx_wr = 0;
  endtask

  // R3 monitor on the bus side: compare head against scoreboard, then pop
  task automatic tx_drain_one();
    logic [8:0] e;
    @(negedge clk);
    e = tx_q.pop_front();
    chk("R3 avail", {31'h0, bus_tx_avail}, 32'h1);
    chk("R3 byte+last", {23'h0, bus_tx_last, bus_tx_data}, {23'h0, e});
    bus_tx_pop = 1;
    @(negedge clk); bus_tx_pop = 0;
  endtask

  task automatic tx_raw_pop();
    @(negedge clk); bus_tx_pop = 1;
    @(negedge clk); bus_tx_pop = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); bus_rx_push = 1; bus_rx_data = d;
    if (rx_q.size() < DEPTH) rx_q.push_back(d);
    @(negedge clk); bus_rx_push = 0;
  endtask

  task automatic rx_read(input logic half);
    @(negedge clk); rx_rd = 1; rx_rd_half = half;
    @(negedge clk); rx_rd = 0; rx_rd_half = 0;
    #1;
  endtask

  // inbound monitor: capture request at the edge, compare result at falling edge
  logic req_q = 0, half_q = 0;
  always @(posedge clk) begin
    req_q  <= rx_rd;
    half_q <= rx_rd_half;
  end
  always @(negedge clk) begin
    if (req_q) begin
      logic [15:0] e;
      if (half_q && rx_q.size() >= 2) begin
        e = {rx_q[1], rx_q[0]};
        void'(rx_q.pop_front()); void'(rx_q.pop_front());
        chk("R5 pair read", {16'h0, rx_rdata}, {16'h0, e});
      end else if (!half_q && rx_q.size() >= 1) begin
        e = {8'h00, rx_q[0]};
        void'(rx_q.pop_front());
        chk("R4 byte read", {16'h0, rx_rdata}, {16'h0, e});
      end else begin
        e = last_rd;
        chk("R5 ignored read holds data", {16'h0, rx_rdata}, {16'h0, e});
      end
      last_rd = e;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl word", ctl_rdata, 32'h8000_00B0);
    chk("R1 rx_rdata", {16'h0, rx_rdata}, 32'h0);
    chk("R1 err_flags", {28'h0, err_flags}, 32'h0);
    chk("R1 triggers", {30'h0, tx_trig, rx_trig}, 32'h2);

    // R2 locked and unlocked code writes
    ctl_write(8'h50);
    chk("R2 locked write", ctl_rdata, 32'h8000_00B0);
    ctl_write(8'h18);
    chk("R2 unlocked write", {24'h0, ctl_rdata[7:0]}, 32'h10);

    // R3 / R6 / R10 outbound message
    tx_push(8'hA1, 0); tx_push(8'hB2, 0); tx_push(8'hC3, 0);
    tx_push(8'hD4, 0); tx_push(8'hE5, 1);
    chk_status("R6");
    tx_drain_one();
    chk_status("R10");
    repeat (4) tx_drain_one();
    @(negedge clk);
    chk("R3 empty avail", {31'h0, bus_tx_avail}, 32'h0);

    // R4 / R5 inbound reads
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    chk_status("R6 rx");
    rx_read(0);
    rx_read(1);
    chk_status("R6 after reads");
    rx_push(8'h44);
    rx_read(1);
    chk("R5 short pair keeps count", {27'h0, ctl_rdata[28:24]}, 32'h1);
    chk("R8 rx underflow flag", {28'h0, err_flags}, 32'h8);
    rx_read(0);
    rx_read(0);
    chk("R8 rx underflow sticky", {28'h0, err_flags}, 32'h8);
    ctl_write(8'h02);
    chk("R9 rx flush clears", {28'h0, err_flags}, 32'h0);
    chk_status("R9 rx flush");

    // R7 outbound overflow, R8 underflow, R9 flush
    for (int i = 0; i < DEPTH + 1; i++) tx_push(8'(i * 3 + 1), i[0]);
    chk_status("R7 full");
    chk("R7 tx overflow", {28'h0, err_flags}, 32'h1);
    for (int i = 0; i < DEPTH; i++) tx_drain_one();
    tx_raw_pop();
    chk("R8 tx underflow", {28'h0, err_flags}, 32'h3);
    tx_push(8'h5A, 0); tx_push(8'h5B, 1);
    ctl_write(8'h01);
    chk("R9 tx flush", {28'h0, err_flags}, 32'h0);
    chk_status("R9 tx flush");
    @(negedge clk);
    chk("R9 avail after flush", {31'h0, bus_tx_avail}, 32'h0);

    // R7 inbound overflow with codes tx=0 rx=3
    ctl_write(8'hC8);
    for (int i = 0; i < DEPTH + 1; i++) rx_push(8'(i * 17 + 2));
    chk_status("R7 rx full");
    chk("R7 rx overflow", {28'h0, err_flags}, 32'h4);
    for (int i = 0; i < DEPTH / 2; i++) rx_read(1);
    chk_status("R10 rx drained");

    // mixed traffic across pointer wrap
    ctl_write(8'h03);
    ctl_write(8'h68);
    for (int i = 0; i < 40; i++) begin
      tx_push(8'(i * 13), (i % 5) == 4);
      if ((i % 3) == 2) begin tx_drain_one(); tx_drain_one(); end
    end
    chk_status("R6 mixed tx");
    while (tx_q.size() > 0) tx_drain_one();
    for (int i = 0; i < 30; i++) begin
      rx_push(8'(i * 29 + 5));
      if ((i % 4) == 3) begin rx_read(1); rx_read(0); end
    end
    chk_status("R6 mixed rx");
    while (rx_q.size() > 0) rx_read(rx_q.size() >= 2);
    chk("R8 no stray errors", {28'h0, err_flags}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule